// File: doc/BRIEF.md
# Two-Channel Interrupt Vector Arbiter

This block merges the interrupt sources of two serial channels, named A and B, into a single interrupt request line. Each channel has three sources: receive, transmit and break. A receive source is raised by a received byte and cleared by a data read. A transmit source is raised by every data write. A break pulse latches a sticky break status.

For each channel the block tracks whether receive or transmit is currently under service. At most one of the two is under service at any time. It keeps one shared vector byte that names the source that last entered service, in a low-bit or high-bit encoding chosen per channel. It also presents a pending byte that software can read. Two software commands act on a channel: one clears transmit-pending, and one clears whichever source is under service. Clearing a source hands service to the other source of the same channel if that source is still pending, and the vector is rewritten for it.

Event pulses and commands are sampled on the rising clock edge. Pending, service, break and vector state are registered. The request line is formed combinationally from that state and the live enable inputs.

Top module: `irq_vec_arbiter`

## Requirements
- R1: `irq_o` is high exactly when either channel has a request. A channel requests when any of these holds: its `tx_ie_i` bit is set and transmit is pending; its 2-bit `rx_mode_i` field equals 01 or 10 and receive is pending; its `brk_ie_i` bit is set and its break status is set. The request follows the current enable inputs without a clock edge.
- R2: After the next edge, a `rx_byte_i` pulse sets that channel's receive-pending, a `data_rd_i` pulse clears it, and a `data_wr_i` pulse sets its transmit-pending.
- R3: Vector codes with the channel's `stat_hi_i` bit clear are: A receive 0x0C, A transmit 0x08, B receive 0x04, no source 0x06. With the bit set they are: A receive 0x30, A transmit 0x10, B receive 0x20, no source 0x60. B transmit is always 0x00. The vector is 0x06 after `rst_n`.
- R4: A raised source enters service, and rewrites the vector, only if the other source of its channel is not under service. A source raised while blocked leaves the vector unchanged.
- R5: Command code 3'b101 (`cmd_vld_i` with the channel's 3-bit `cmd_op_i` field) clears transmit-pending and transmit-service and sets the vector to "no source". If receive is still pending, receive is then raised again, so it takes service and rewrites the vector.
- R6: Command code 3'b111 clears receive if receive is under service. Otherwise it clears transmit if transmit is under service. Each clear is followed by the hand-over of R5. With neither source under service the command changes nothing. Other codes have no effect.
- R7: The pending byte `pend_o` is laid out as follows: bit 5 is A receive, bit 4 is A transmit, bit 3 is A break, bit 2 is B receive, bit 1 is B transmit, bit 0 is B break, and bits 7:6 are zero.
- R8: A `brk_i` pulse sets the channel's break status (`brk_o`, and its break bit in `pend_o`). The status stays set until a channel reset.
- R9: `chan_rst_i` clears that channel's pending, service and break state. It leaves the vector and the other channel unchanged.
- R10: Events arriving in the same cycle are applied with channel A before channel B. Within a channel the order is: reset (which discards the rest), command, data read, data write, received byte, break.
- R11: Within a channel, receive and transmit are never under service at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_rst_i | input | 2 | Per-channel reset pulse (bit 0 = A, bit 1 = B) |
| cmd_vld_i | input | 2 | Per-channel command strobe |
| cmd_op_i | input | 6 | Command codes, [2:0] for A, [5:3] for B |
| data_rd_i | input | 2 | Data read pulse per channel |
| data_wr_i | input | 2 | Data write pulse per channel |
| rx_byte_i | input | 2 | Byte received pulse per channel |
| brk_i | input | 2 | Break detected pulse per channel |
| tx_ie_i | input | 2 | Transmit interrupt enable per channel |
| rx_mode_i | input | 4 | Receive interrupt mode, [1:0] for A, [3:2] for B |
| brk_ie_i | input | 2 | Break interrupt enable per channel |
| stat_hi_i | input | 2 | Per-channel high-bit vector encoding select |
| irq_o | output | 1 | Combined interrupt request |
| vec_o | output | 8 | Modified interrupt vector |
| pend_o | output | 8 | Pending byte |
| brk_o | output | 2 | Sticky break status per channel |

## Verification
Pulses, commands and channel resets take effect on the next rising edge. `vec_o`, `pend_o` and `brk_o` therefore show the result one register stage later, and the bench samples them 1 ns after that edge. `irq_o` depends on registered state and the live enables. The bench therefore drives new enables at the falling edge and compares `irq_o` 1 ns later, against a model that has not yet applied that cycle's events. Hand-overs inside one command (the transient "no source" vector followed by a re-raise) never reach the port. The directed cases therefore check only the final vector after the edge.

// File: rtl/ivarb_pkg.sv
package ivarb_pkg;
  localparam int NCH   = 2;
  localparam int VW    = 8;
  localparam int OPW   = 3;
  localparam int MODEW = 2;
  localparam int PBITS = 3;

  localparam logic [OPW-1:0] OP_CLR_TX  = 3'b101;
  localparam logic [OPW-1:0] OP_CLR_SVC = 3'b111;

  typedef struct packed {
    logic rx_pend;
    logic tx_pend;
    logic rx_svc;
    logic tx_svc;
    logic brk;
  } chan_st_t;

  typedef struct packed {
    chan_st_t        st;
    logic [VW-1:0]   vec;
  } ctx_t;

  function automatic logic [VW-1:0] vec_none(input logic hi);
    return hi ? 8'h60 : 8'h06;
  endfunction

  function automatic logic [VW-1:0] vec_rx(input logic is_b, input logic hi);
    if (is_b) return hi ? 8'h20 : 8'h04;
    return hi ? 8'h30 : 8'h0C;
  endfunction

  function automatic logic [VW-1:0] vec_tx(input logic is_b, input logic hi);
    if (is_b) return 8'h00;
    return hi ? 8'h10 : 8'h08;
  endfunction

  function automatic logic rx_mode_on(input logic [MODEW-1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  function automatic ctx_t raise_rx(input ctx_t c, input logic is_b, input logic hi);
    ctx_t r = c;
    r.st.rx_pend = 1'b1;
    if (!r.st.tx_svc) begin
      r.st.rx_svc = 1'b1;
      r.vec       = vec_rx(is_b, hi);
    end
    return r;
  endfunction

  function automatic ctx_t raise_tx(input ctx_t c, input logic is_b, input logic hi);
    ctx_t r = c;
    r.st.tx_pend = 1'b1;
    if (!r.st.rx_svc) begin
      r.st.tx_svc = 1'b1;
      r.vec       = vec_tx(is_b, hi);
    end
    return r;
  endfunction

  function automatic ctx_t drop_rx(input ctx_t c, input logic is_b, input logic hi);
    ctx_t r = c;
    r.st.rx_pend = 1'b0;
    r.st.rx_svc  = 1'b0;
    r.vec        = vec_none(hi);
    if (r.st.tx_pend) r = raise_tx(r, is_b, hi);
    return r;
  endfunction

  function automatic ctx_t drop_tx(input ctx_t c, input logic is_b, input logic hi);
    ctx_t r = c;
    r.st.tx_pend = 1'b0;
    r.st.tx_svc  = 1'b0;
    r.vec        = vec_none(hi);
    if (r.st.rx_pend) r = raise_rx(r, is_b, hi);
    return r;
  endfunction

  function automatic logic [PBITS-1:0] pend_bits(input chan_st_t s);
    return {s.rx_pend, s.tx_pend, s.brk};
  endfunction
endpackage

// File: rtl/ivarb_req.sv
module ivarb_req
  import ivarb_pkg::*;
(
  input  logic             rx_pend_i,
  input  logic             tx_pend_i,
  input  logic             brk_i,
  input  logic             tx_ie_i,
  input  logic [MODEW-1:0] rx_mode_i,
  input  logic             brk_ie_i,
  output logic             req_o
);
  always_comb begin
    req_o = (tx_ie_i && tx_pend_i) ||
            (rx_mode_on(rx_mode_i) && rx_pend_i) ||
            (brk_ie_i && brk_i);
  end
endmodule

// File: rtl/ivarb_step.sv
module ivarb_step
  import ivarb_pkg::*;
#(
  parameter bit IS_B = 1'b0
)(
  input  chan_st_t        st_i,
  input  logic [VW-1:0]   vec_i,
  input  logic            hi_i,
  input  logic            rst_i,
  input  logic            cmd_vld_i,
  input  logic [OPW-1:0]  cmd_op_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic            rxb_i,
  input  logic            brk_i,
  output chan_st_t        st_o,
  output logic [VW-1:0]   vec_o
);
  ctx_t cx;

  // Events applied in fixed order: reset, command, read, write, receive, break (R10)
  always_comb begin
    cx.st  = st_i;
    cx.vec = vec_i;
    if (rst_i) begin
      cx.st = '0;
    end else begin
      if (cmd_vld_i) begin
        if (cmd_op_i == OP_CLR_TX) begin
          cx = drop_tx(cx, IS_B, hi_i);
        end else if (cmd_op_i == OP_CLR_SVC) begin
          if (cx.st.rx_svc)      cx = drop_rx(cx, IS_B, hi_i);
          else if (cx.st.tx_svc) cx = drop_tx(cx, IS_B, hi_i);
        end
      end
      if (rd_i)  cx = drop_rx(cx, IS_B, hi_i);
      if (wr_i)  cx = raise_tx(cx, IS_B, hi_i);
      if (rxb_i) cx = raise_rx(cx, IS_B, hi_i);
      if (brk_i) cx.st.brk = 1'b1;
    end
    st_o  = cx.st;
    vec_o = cx.vec;
  end
endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
  import ivarb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       chan_rst_i,
  input  logic [NCH-1:0]       cmd_vld_i,
  input  logic [NCH*OPW-1:0]   cmd_op_i,
  input  logic [NCH-1:0]       data_rd_i,
  input  logic [NCH-1:0]       data_wr_i,
  input  logic [NCH-1:0]       rx_byte_i,
  input  logic [NCH-1:0]       brk_i,
  input  logic [NCH-1:0]       tx_ie_i,
  input  logic [NCH*MODEW-1:0] rx_mode_i,
  input  logic [NCH-1:0]       brk_ie_i,
  input  logic [NCH-1:0]       stat_hi_i,
  output logic                 irq_o,
  output logic [VW-1:0]        vec_o,
  output logic [VW-1:0]        pend_o,
  output logic [NCH-1:0]       brk_o
);
  localparam logic [VW-1:0] VEC_RST = vec_none(1'b0);

  chan_st_t [NCH-1:0] st_q;
  chan_st_t [NCH-1:0] st_d;
  logic [VW-1:0]      vec_q;
  logic [VW-1:0]      vchain [NCH+1];

  // Named internal events for the checker
  logic [NCH-1:0]     rx_svc_w;
  logic [NCH-1:0]     tx_svc_w;
  logic [NCH-1:0]     req_w;

  assign vchain[0] = vec_q;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      ivarb_step #(.IS_B(c != 0)) u_step (
        .st_i      (st_q[c]),
        .vec_i     (vchain[c]),
        .hi_i      (stat_hi_i[c]),
        .rst_i     (chan_rst_i[c]),
        .cmd_vld_i (cmd_vld_i[c]),
        .cmd_op_i  (cmd_op_i[c*OPW +: OPW]),
        .rd_i      (data_rd_i[c]),
        .wr_i      (data_wr_i[c]),
        .rxb_i     (rx_byte_i[c]),
        .brk_i     (brk_i[c]),
        .st_o      (st_d[c]),
        .vec_o     (vchain[c+1])
      );

      ivarb_req u_req (
        .rx_pend_i (st_q[c].rx_pend),
        .tx_pend_i (st_q[c].tx_pend),
        .brk_i     (st_q[c].brk),
        .tx_ie_i   (tx_ie_i[c]),
        .rx_mode_i (rx_mode_i[c*MODEW +: MODEW]),
        .brk_ie_i  (brk_ie_i[c]),
        .req_o     (req_w[c])
      );

      assign rx_svc_w[c] = st_q[c].rx_svc;
      assign tx_svc_w[c] = st_q[c].tx_svc;
      assign brk_o[c]    = st_q[c].brk;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= '0;
      vec_q <= VEC_RST;
    end else begin
      st_q  <= st_d;
      vec_q <= vchain[NCH];
    end
  end

  always_comb begin
    pend_o = '0;
    for (int i = 0; i < NCH; i++) begin
      pend_o[PBITS*(NCH-1-i) +: PBITS] = pend_bits(st_q[i]);
    end
  end

  assign irq_o = |req_w;
  assign vec_o = vec_q;
endmodule

// File: rtl/ivarb_chk.sv
module ivarb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] chan_rst_i,
  input logic [1:0] data_wr_i,
  input logic [1:0] rx_byte_i,
  input logic       irq_o,
  input logic [7:0] vec_o,
  input logic [7:0] pend_o,
  input logic [1:0] brk_o,
  input logic [1:0] rx_svc_w,
  input logic [1:0] tx_svc_w
);
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n) (pend_o == 8'h00) |-> !irq_o); // R1
  AST_WR_SETS_TX_A: assert property (@(posedge clk) disable iff (!rst_n) (data_wr_i[0] && !chan_rst_i[0]) |=> pend_o[4]); // R2
  AST_WR_SETS_TX_B: assert property (@(posedge clk) disable iff (!rst_n) (data_wr_i[1] && !chan_rst_i[1]) |=> pend_o[1]); // R2
  AST_RXB_SETS_RX_A: assert property (@(posedge clk) disable iff (!rst_n) (rx_byte_i[0] && !chan_rst_i[0]) |=> pend_o[5]); // R2
  AST_RXB_SETS_RX_B: assert property (@(posedge clk) disable iff (!rst_n) (rx_byte_i[1] && !chan_rst_i[1]) |=> pend_o[2]); // R2
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) vec_o inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h30, 8'h60}); // R3
  AST_RX_SVC_PEND_A: assert property (@(posedge clk) disable iff (!rst_n) rx_svc_w[0] |-> pend_o[5]); // R4
  AST_TX_SVC_PEND_B: assert property (@(posedge clk) disable iff (!rst_n) tx_svc_w[1] |-> pend_o[1]); // R4
  AST_PEND_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) pend_o[7:6] == 2'b00); // R7
  AST_BRK_STICKY_A: assert property (@(posedge clk) disable iff (!rst_n) (brk_o[0] && !chan_rst_i[0]) |=> brk_o[0]); // R8
  AST_BRK_STICKY_B: assert property (@(posedge clk) disable iff (!rst_n) (brk_o[1] && !chan_rst_i[1]) |=> brk_o[1]); // R8
  AST_CHRST_CLEARS_A: assert property (@(posedge clk) disable iff (!rst_n) chan_rst_i[0] |=> (pend_o[5:3] == 3'b000 && !rx_svc_w[0] && !tx_svc_w[0])); // R9
  AST_CHRST_CLEARS_B: assert property (@(posedge clk) disable iff (!rst_n) chan_rst_i[1] |=> (pend_o[2:0] == 3'b000 && !rx_svc_w[1] && !tx_svc_w[1])); // R9
  AST_CHRST_KEEPS_VEC: assert property (@(posedge clk) disable iff (!rst_n) (chan_rst_i == 2'b11) |=> $stable(vec_o)); // R9
  AST_SVC_EXCL_A: assert property (@(posedge clk) disable iff (!rst_n) !(rx_svc_w[0] && tx_svc_w[0])); // R11
  AST_SVC_EXCL_B: assert property (@(posedge clk) disable iff (!rst_n) !(rx_svc_w[1] && tx_svc_w[1])); // R11
endmodule

bind irq_vec_arbiter ivarb_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chan_rst_i (chan_rst_i),
  .data_wr_i  (data_wr_i),
  .rx_byte_i  (rx_byte_i),
  .irq_o      (irq_o),
  .vec_o      (vec_o),
  .pend_o     (pend_o),
  .brk_o      (brk_o),
  .rx_svc_w   (rx_svc_w),
  .tx_svc_w   (tx_svc_w)
);

// File: tb/sim_irq_vec_arbiter.sv
`timescale 1ns/1ps
module sim_irq_vec_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] chan_rst_i, cmd_vld_i, data_rd_i, data_wr_i, rx_byte_i, brk_i;
  logic [5:0] cmd_op_i;
  logic [1:0] tx_ie_i, brk_ie_i, stat_hi_i;
  logic [3:0] rx_mode_i;
  logic       irq_o;
  logic [7:0] vec_o, pend_o;
  logic [1:0] brk_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model
  bit       mrp [2];
  bit       mtp [2];
  bit       mrs [2];
  bit       mts [2];
  bit       mbk [2];
  bit [7:0] mvec;

  always #4 clk = ~clk;

  irq_vec_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .chan_rst_i(chan_rst_i), .cmd_vld_i(cmd_vld_i),
    .cmd_op_i(cmd_op_i), .data_rd_i(data_rd_i), .data_wr_i(data_wr_i),
    .rx_byte_i(rx_byte_i), .brk_i(brk_i), .tx_ie_i(tx_ie_i), .rx_mode_i(rx_mode_i),
    .brk_ie_i(brk_ie_i), .stat_hi_i(stat_hi_i), .irq_o(irq_o), .vec_o(vec_o),
    .pend_o(pend_o), .brk_o(brk_o)
  );

  // kind: 0 = no source, 1 = receive, 2 = transmit; ch: 0 = A, 1 = B
  function automatic bit [7:0] code(int kind, int ch, bit hi);
    case (kind)
      1:       return (ch == 0) ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
      2:       return (ch == 0) ? (hi ? 8'h10 : 8'h08) : 8'h00;
      default: return hi ? 8'h60 : 8'h06;
    endcase
  endfunction

  task automatic m_rx_on(int c);
    mrp[c] = 1;
    if (!mts[c]) begin mrs[c] = 1; mvec = code(1, c, stat_hi_i[c]); end
  endtask

  task automatic m_tx_on(int c);
    mtp[c] = 1;
    if (!mrs[c]) begin mts[c] = 1; mvec = code(2, c, stat_hi_i[c]); end
  endtask

  task automatic m_rx_off(int c);
    mrp[c] = 0; mrs[c] = 0; mvec = code(0, c, stat_hi_i[c]);
    if (mtp[c]) m_tx_on(c);
  endtask

  task automatic m_tx_off(int c);
    mtp[c] = 0; mts[c] = 0; mvec = code(0, c, stat_hi_i[c]);
    if (mrp[c]) m_rx_on(c);
  endtask

  task automatic model_apply();
    for (int c = 0; c < 2; c++) begin
      if (chan_rst_i[c]) begin
        mrp[c] = 0; mtp[c] = 0; mrs[c] = 0; mts[c] = 0; mbk[c] = 0;
      end else begin
        if (cmd_vld_i[c]) begin
          if (cmd_op_i[c*3 +: 3] == 3'd5) m_tx_off(c);
          else if (cmd_op_i[c*3 +: 3] == 3'd7) begin
            if (mrs[c]) m_rx_off(c);
            else if (mts[c]) m_tx_off(c);
          end
        end
        if (data_rd_i[c]) m_rx_off(c);
        if (data_wr_i[c]) m_tx_on(c);
        if (rx_byte_i[c]) m_rx_on(c);
        if (brk_i[c]) mbk[c] = 1;
      end
    end
  endtask

  function automatic bit exp_irq();
    bit r = 0;
    for (int c = 0; c < 2; c++) begin
      bit rxon = (rx_mode_i[c*2 +: 2] == 2'b01) || (rx_mode_i[c*2 +: 2] == 2'b10);
      r |= (tx_ie_i[c] & mtp[c]) | (rxon & mrp[c]) | (brk_ie_i[c] & mbk[c]);
    end
    return r;
  endfunction

  function automatic bit [7:0] exp_pend();
    return {2'b00, mrp[0], mtp[0], mbk[0], mrp[1], mtp[1], mbk[1]};
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 irq", {7'd0, irq_o}, {7'd0, exp_irq()});
    chk("R3/R4 vector", vec_o, mvec);
    chk("R7 pending", pend_o, exp_pend());
    chk("R8 break", {6'd0, brk_o}, {6'd0, mbk[1], mbk[0]});
  endtask

  task automatic clear_events();
    chan_rst_i = 0; cmd_vld_i = 0; cmd_op_i = 0;
    data_rd_i = 0; data_wr_i = 0; rx_byte_i = 0; brk_i = 0;
  endtask

  // called at a falling edge after inputs are set; returns 1 ns after the rising edge
  task automatic tick();
    #1;
    compare_all();
    model_apply();
    @(posedge clk);
    #1;
    clear_events();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clear_events();
    tx_ie_i = 2'b11; rx_mode_i = 4'b0101; brk_ie_i = 2'b00; stat_hi_i = 2'b00;
    for (int c = 0; c < 2; c++) begin mrp[c]=0; mtp[c]=0; mrs[c]=0; mts[c]=0; mbk[c]=0; end
    mvec = 8'h06;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R3 reset vector", vec_o, 8'h06);
    chk("R7 reset pending", pend_o, 8'h00);
    chk("R1 reset irq", {7'd0, irq_o}, 8'h00);

    // Channel A, low encoding
    @(negedge clk); data_wr_i = 2'b01; tick();
    chk("R2 write sets tx A", pend_o, 8'h10);
    chk("R4 tx A enters service", vec_o, 8'h08);
    chk("R1 irq on tx", {7'd0, irq_o}, 8'h01);
    @(negedge clk); rx_byte_i = 2'b01; tick();
    chk("R2 byte sets rx A", pend_o, 8'h30);
    chk("R11 rx blocked keeps vector", vec_o, 8'h08);
    @(negedge clk); cmd_vld_i = 2'b01; cmd_op_i = 6'o07; tick();
    chk("R6 clear svc hands to rx", vec_o, 8'h0C);
    chk("R6 clear svc pending", pend_o, 8'h20);
    @(negedge clk); cmd_vld_i = 2'b01; cmd_op_i = 6'o07; tick();
    chk("R6 clear svc rx", vec_o, 8'h06);
    chk("R6 clear svc rx pending", pend_o, 8'h00);
    @(negedge clk); cmd_vld_i = 2'b01; cmd_op_i = 6'o07; tick();
    chk("R6 idle clear no effect", vec_o, 8'h06);

    // Channel B, high encoding
    stat_hi_i = 2'b10;
    @(negedge clk); rx_byte_i = 2'b10; tick();
    chk("R3 B rx high", vec_o, 8'h20);
    chk("R7 B rx bit", pend_o, 8'h04);
    @(negedge clk); data_wr_i = 2'b10; tick();
    chk("R4 B tx blocked", vec_o, 8'h20);
    chk("R7 B tx bit", pend_o, 8'h06);
    @(negedge clk); cmd_vld_i = 2'b10; cmd_op_i = 6'o50; tick();
    chk("R5 clear tx re-raises rx", vec_o, 8'h20);
    chk("R5 clear tx pending", pend_o, 8'h04);
    @(negedge clk); data_rd_i = 2'b10; tick();
    chk("R2 read clears rx", pend_o, 8'h00);
    chk("R3 none high", vec_o, 8'h60);
    @(negedge clk); data_wr_i = 2'b10; tick();
    chk("R3 B tx code", vec_o, 8'h00);
    @(negedge clk); cmd_vld_i = 2'b10; cmd_op_i = 6'o50; tick();
    chk("R5 clear tx to none", vec_o, 8'h60);

    // Break on A
    tx_ie_i = 2'b00; rx_mode_i = 4'b0000;
    @(negedge clk); brk_i = 2'b01; tick();
    chk("R8 break status", {6'd0, brk_o}, 8'h01);
    chk("R7 break bit", pend_o, 8'h08);
    chk("R1 break masked", {7'd0, irq_o}, 8'h00);
    @(negedge clk); brk_ie_i = 2'b01; tick();
    chk("R1 break enabled", {7'd0, irq_o}, 8'h01);
    chk("R8 break sticky", {6'd0, brk_o}, 8'h01);
    @(negedge clk); chan_rst_i = 2'b01; tick();
    chk("R9 reset clears break", {6'd0, brk_o}, 8'h00);
    chk("R9 reset keeps vector", vec_o, 8'h60);

    // Same-cycle ordering
    stat_hi_i = 2'b00; tx_ie_i = 2'b11; rx_mode_i = 4'b1010; brk_ie_i = 2'b00;
    @(negedge clk); rx_byte_i = 2'b01; tick();
    chk("R3 A rx low", vec_o, 8'h0C);
    @(negedge clk); data_rd_i = 2'b01; data_wr_i = 2'b01; rx_byte_i = 2'b11; tick();
    chk("R10 order vector", vec_o, 8'h04);
    chk("R10 order pending", pend_o, 8'h34);
    @(negedge clk); chan_rst_i = 2'b11; tick();
    chk("R9 both reset", pend_o, 8'h00);
    chk("R9 vector kept", vec_o, 8'h04);

    // Constrained random
    void'($urandom(32'd7919));
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(15) == 0) tx_ie_i = 2'($urandom);
      if ($urandom_range(15) == 0) rx_mode_i = 4'($urandom);
      if ($urandom_range(15) == 0) brk_ie_i = 2'($urandom);
      if ($urandom_range(15) == 0) stat_hi_i = 2'($urandom);
      data_rd_i  = {($urandom_range(5) == 0), ($urandom_range(5) == 0)};
      data_wr_i  = {($urandom_range(5) == 0), ($urandom_range(5) == 0)};
      rx_byte_i  = {($urandom_range(5) == 0), ($urandom_range(5) == 0)};
      brk_i      = {($urandom_range(30) == 0), ($urandom_range(30) == 0)};
      chan_rst_i = {($urandom_range(40) == 0), ($urandom_range(40) == 0)};
      cmd_vld_i  = {($urandom_range(4) == 0), ($urandom_range(4) == 0)};
      cmd_op_i   = 6'($urandom);
      tick();
    end
    @(negedge clk); #1; compare_all();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule